// File: doc/BRIEF.md
# Two-Level Programmable Interrupt Prioritizer

This block takes a set of maskable interrupt request lines plus one non-maskable request and reduces them to a single interrupt request towards a CPU, together with a registered index that names the winning source. Software sorts each maskable source into one of two groups, a high group or a low group, by writing a per-source level register. Inside a group, the source with the lower line number wins. The non-maskable request outranks both groups and ignores every enable and level setting.

The block tracks which levels are being serviced, so that nested handlers work. Three in-service flags are kept, one each for the low group, the high group and the non-maskable level. An acknowledge marks the offered level as in service. A return-from-interrupt clears the highest flag that is set. A new request is offered only when its level is strictly above the highest level in service, so only upward preemption is possible.

The offer logic is a two-state machine. In `ST_WAIT` it arbitrates every cycle. The transition `WAIT_TO_OFFER` fires when the best candidate outranks the current service level; it captures the index and level and raises the request. `ST_OFFER` holds the request and index stable. The transition `OFFER_TO_WAIT` fires on acknowledge, which also records the offered level as in service.

Top module: `irq_prio_two_level`

## Requirements
- R1: After reset the interrupt request output is 0. All enable bits, the global enable, the level register and all in-service flags are cleared, so no maskable request is offered until software enables it.
- R2: The non-maskable request wins over every maskable request, whatever the enable bits, the global enable and the level register hold. It is offered with index `N_SRC` (5 by default).
- R3: A maskable source i is eligible only when its enable bit i and the global enable are both 1.
- R4: Level register bit i places source i in the high group when 1 and in the low group when 0. An eligible high-group source always wins over an eligible low-group source. With the register set to binary 00011, sources 0 and 1 win over every other pending source.
- R5: Inside one group the lowest-numbered eligible source wins. The index output equals that source number.
- R6: The request output is registered. It rises one clock after a winning request is present at the inputs, and it never rises without a request in the cycle before.
- R7: While the request output is high and no acknowledge is given, the request output and the index stay unchanged, even if a stronger request arrives. On an acknowledge the request output drops in the next cycle.
- R8: An acknowledge marks the offered level in service. While a level is in service, requests at that level or below are not offered, and a request at a strictly higher level is offered.
- R9: A return-from-interrupt clears exactly one in-service flag, the highest one that is set.
- R10: A write to the enable, global enable or level register is used by the arbitration in the cycle after the write edge, not at the write edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_SRC | Maskable request lines, bit i is source i |
| nmi_i | input | 1 | Non-maskable request |
| en_we | input | 1 | Write strobe for the per-source enable register |
| en_wdata | input | N_SRC | Per-source enable value |
| gen_we | input | 1 | Write strobe for the global enable |
| gen_wdata | input | 1 | Global enable value |
| lvl_we | input | 1 | Write strobe for the level register |
| lvl_wdata | input | N_SRC | Level value, 1 = high group |
| ack_i | input | 1 | CPU acknowledge of the offered request |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Single interrupt request to the CPU |
| vec_o | output | IDX_W | Index of the offered source, N_SRC for the non-maskable one |

## Verification
The assertions take for granted that the CPU pulses the acknowledge only while the request output is high. They also assume that a return-from-interrupt never falls in the same cycle as an acknowledge, because the flag-count property would not hold then. The bench keeps to both rules: it drives the acknowledge only after it has seen the request output high, and it separates each acknowledge and return by at least one clock. Configuration writes are made while the request lines are held low, except in the one directed check that tests write timing.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Service levels, ordered so a plain compare tells which is stronger.
    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_NMI  = 2'd3
    } lvl_e;

    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_OFFER = 1'b1
    } offer_st_e;

    localparam int unsigned NUM_LVL_FLAGS = 3;

endpackage

// File: rtl/irq_prio_cfg_regs.sv
module irq_prio_cfg_regs #(
    parameter int unsigned N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic [N_SRC-1:0] en_wdata,
    input  logic             gen_we,
    input  logic             gen_wdata,
    input  logic             lvl_we,
    input  logic [N_SRC-1:0] lvl_wdata,
    output logic [N_SRC-1:0] en_q,
    output logic             gen_q,
    output logic [N_SRC-1:0] lvl_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            gen_q <= 1'b0;
            lvl_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (gen_we) gen_q <= gen_wdata;
            if (lvl_we) lvl_q <= lvl_wdata;
        end
    end

endmodule

// File: rtl/irq_prio_first_set.sv
module irq_prio_first_set #(
    parameter int unsigned N_SRC = 5,
    parameter int unsigned IDX_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0] mask_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down, so the lowest set position is kept last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_service_track.sv
module irq_prio_service_track
    import irq_prio_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  lvl_e                     set_lvl,
    input  logic                     clr_en,
    output logic [NUM_LVL_FLAGS-1:0] svc_q,
    output lvl_e                     cur_lvl
);

    logic [NUM_LVL_FLAGS-1:0] svc_d;

    always_comb begin
        svc_d = svc_q;
        if (clr_en) begin
            if (svc_q[2])      svc_d[2] = 1'b0;
            else if (svc_q[1]) svc_d[1] = 1'b0;
            else               svc_d[0] = 1'b0;
        end
        if (set_en) begin
            unique case (set_lvl)
                LVL_LOW:  svc_d[0] = 1'b1;
                LVL_HIGH: svc_d[1] = 1'b1;
                LVL_NMI:  svc_d[2] = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end

    always_comb begin
        if (svc_q[2])      cur_lvl = LVL_NMI;
        else if (svc_q[1]) cur_lvl = LVL_HIGH;
        else if (svc_q[0]) cur_lvl = LVL_LOW;
        else               cur_lvl = LVL_NONE;
    end

endmodule

// File: rtl/irq_prio_two_level.sv
module irq_prio_two_level
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_SRC = 5,
    parameter int unsigned IDX_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             nmi_i,
    input  logic             en_we,
    input  logic [N_SRC-1:0] en_wdata,
    input  logic             gen_we,
    input  logic             gen_wdata,
    input  logic             lvl_we,
    input  logic [N_SRC-1:0] lvl_wdata,
    input  logic             ack_i,
    input  logic             reti_i,
    output logic             irq_o,
    output logic [IDX_W-1:0] vec_o
);

    localparam int unsigned N_GRP = 2;
    localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(N_SRC);

    logic [N_SRC-1:0] en_q;
    logic             gen_q;
    logic [N_SRC-1:0] lvl_q;

    irq_prio_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .gen_we    (gen_we),
        .gen_wdata (gen_wdata),
        .lvl_we    (lvl_we),
        .lvl_wdata (lvl_wdata),
        .en_q      (en_q),
        .gen_q     (gen_q),
        .lvl_q     (lvl_q)
    );

    logic [N_SRC-1:0] elig;
    assign elig = req_i & en_q & {N_SRC{gen_q}};

    // Group 0 = low, group 1 = high.
    logic [N_GRP-1:0]            grp_found;
    logic [N_GRP-1:0][IDX_W-1:0] grp_idx;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic [N_SRC-1:0] grp_mask;
        assign grp_mask = (g == 1) ? (elig & lvl_q) : (elig & ~lvl_q);
        irq_prio_first_set #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
            .mask_i  (grp_mask),
            .found_o (grp_found[g]),
            .idx_o   (grp_idx[g])
        );
    end

    lvl_e             cand_lvl;
    logic [IDX_W-1:0] cand_idx;

    always_comb begin
        if (nmi_i) begin
            cand_lvl = LVL_NMI;
            cand_idx = NMI_IDX;
        end else if (grp_found[1]) begin
            cand_lvl = LVL_HIGH;
            cand_idx = grp_idx[1];
        end else if (grp_found[0]) begin
            cand_lvl = LVL_LOW;
            cand_idx = grp_idx[0];
        end else begin
            cand_lvl = LVL_NONE;
            cand_idx = '0;
        end
    end

    offer_st_e        state_q, state_d;
    lvl_e             offer_lvl_q;
    logic [IDX_W-1:0] vec_q;
    logic [NUM_LVL_FLAGS-1:0] svc_q;
    lvl_e             cur_lvl;
    logic             can_offer;
    logic             take_ack;

    assign can_offer = (cand_lvl > cur_lvl);
    assign take_ack  = (state_q == ST_OFFER) && ack_i;

    irq_prio_service_track u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (take_ack),
        .set_lvl (offer_lvl_q),
        .clr_en  (reti_i),
        .svc_q   (svc_q),
        .cur_lvl (cur_lvl)
    );

    // Next state: WAIT_TO_OFFER on a winning candidate, OFFER_TO_WAIT on acknowledge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (can_offer) state_d = ST_OFFER;
            ST_OFFER: if (ack_i)     state_d = ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Captured outputs: loaded only on WAIT_TO_OFFER.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q       <= '0;
            offer_lvl_q <= LVL_NONE;
        end else if (state_q == ST_WAIT && can_offer) begin
            vec_q       <= cand_idx;
            offer_lvl_q <= cand_lvl;
        end
    end

    assign irq_o = (state_q == ST_OFFER);
    assign vec_o = vec_q;

endmodule

// File: rtl/irq_prio_two_level_chk.sv
module irq_prio_two_level_chk #(
    parameter int unsigned N_SRC = 5,
    parameter int unsigned IDX_W = $clog2(N_SRC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] req_i,
    input logic             nmi_i,
    input logic             ack_i,
    input logic             reti_i,
    input logic             irq_o,
    input logic [IDX_W-1:0] vec_o,
    input logic [2:0]       svc_q,
    input logic [1:0]       offer_lvl,
    input logic [1:0]       cur_lvl
);

    AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(nmi_i || (|req_i))); // R6

    AST_NMI_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && $past(nmi_i)) |-> (vec_o == IDX_W'(N_SRC))); // R2

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(vec_o))); // R7

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o); // R7

    AST_UPWARD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (offer_lvl > $past(cur_lvl))); // R8

    AST_RETI_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !(irq_o && ack_i) && (|svc_q)) |=>
            ($countones(svc_q) == $countones($past(svc_q)) - 1)); // R9

endmodule

bind irq_prio_two_level irq_prio_two_level_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .nmi_i     (nmi_i),
    .ack_i     (ack_i),
    .reti_i    (reti_i),
    .irq_o     (irq_o),
    .vec_o     (vec_o),
    .svc_q     (svc_q),
    .offer_lvl (offer_lvl_q),
    .cur_lvl   (cur_lvl)
);

// File: tb/irq_prio_two_level_tb.sv
module irq_prio_two_level_tb;

    localparam int N = 5;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         nmi = 1'b0;
    logic         en_we = 1'b0, gen_we = 1'b0, lvl_we = 1'b0;
    logic [N-1:0] en_wd = '0, lvl_wd = '0;
    logic         gen_wd = 1'b0;
    logic         ack = 1'b0, reti = 1'b0;
    logic         irq;
    logic [W-1:0] vec;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    irq_prio_two_level #(.N_SRC(N), .IDX_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .nmi_i(nmi),
        .en_we(en_we), .en_wdata(en_wd), .gen_we(gen_we), .gen_wdata(gen_wd),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wd), .ack_i(ack), .reti_i(reti),
        .irq_o(irq), .vec_o(vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected winner with nothing in service; -1 means no request.
    function automatic int model(input logic [N-1:0] r, input logic [N-1:0] e,
                                 input logic [N-1:0] p, input logic g, input logic m);
        logic [N-1:0] el;
        if (m) return N;
        el = r & e & {N{g}};
        for (int i = 0; i < N; i++) if (el[i] && p[i]) return i;
        for (int i = 0; i < N; i++) if (el[i]) return i;
        return -1;
    endfunction

    task automatic cfg(input logic [N-1:0] e, input logic g, input logic [N-1:0] p);
        @(negedge clk);
        en_we = 1; en_wd = e; gen_we = 1; gen_wd = g; lvl_we = 1; lvl_wd = p;
        req = '0; nmi = 0;
        @(negedge clk);
        en_we = 0; gen_we = 0; lvl_we = 0;
    endtask

    task automatic pulse_ack();
        ack = 1;
        @(negedge clk);
        ack = 0;
    endtask

    task automatic pulse_reti();
        reti = 1;
        @(negedge clk);
        reti = 0;
    endtask

    // One arbitration case; leaves nothing in service.
    task automatic run_case(input string tag, input logic [N-1:0] e, input logic g,
                            input logic [N-1:0] p, input logic [N-1:0] r, input logic m);
        int exp;
        exp = model(r, e, p, g, m);
        cfg(e, g, p);
        req = r; nmi = m;
        @(negedge clk);
        chk({tag, " irq"}, int'(irq), (exp >= 0) ? 1 : 0);
        if (exp >= 0) begin
            chk({tag, " vec"}, int'(vec), exp);
            req = '0; nmi = 0;
            pulse_ack();
            pulse_reti();
        end else begin
            req = '0; nmi = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", int'(irq), 0);
        rst_n = 1;
        req = '1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 disabled after reset", int'(irq), 0);
        req = '0;

        // R4 R5: full sweep of level register against request patterns.
        for (int p = 0; p < 32; p++)
            for (int r = 0; r < 32; r++)
                run_case("R4_R5 sweep", '1, 1'b1, N'(p), N'(r), 1'b0);

        // R4: binary 00011 lets sources 0 and 1 win over the rest.
        run_case("R4 lvl 00011 all", '1, 1'b1, 5'b00011, 5'b11111, 1'b0);
        run_case("R4 lvl 00011 src1", '1, 1'b1, 5'b00011, 5'b11110, 1'b0);

        // R2 R3: enables, global enable and the non-maskable line.
        for (int e = 0; e < 32; e++)
            for (int g = 0; g < 2; g++)
                for (int m = 0; m < 2; m++)
                    run_case("R2_R3 mask sweep", N'(e), g[0], 5'b01010, 5'b11111, m[0]);

        // R10: write lands on the same edge the block arbitrates; old value used there.
        cfg('1, 1'b0, '0);
        req = '1;
        @(negedge clk);
        gen_we = 1; gen_wd = 1; lvl_we = 1; lvl_wd = 5'b00100;
        @(negedge clk);
        gen_we = 0; lvl_we = 0;
        chk("R10 no offer at write edge", int'(irq), 0);
        @(negedge clk);
        chk("R10 offer next cycle", int'(irq), 1);
        chk("R10 new level used", int'(vec), 2);
        req = '0;
        pulse_ack();
        pulse_reti();

        // R6 R7 R8 R9: nesting sequence, source 1 high, others low.
        cfg('1, 1'b1, 5'b00010);
        req = 5'b01000;
        @(negedge clk);
        chk("R6 low offer", int'(irq), 1);
        chk("R6 low vec", int'(vec), 3);
        pulse_ack();
        chk("R7 drop after ack", int'(irq), 0);
        req = 5'b11000;
        @(negedge clk);
        @(negedge clk);
        chk("R8 low waits behind low", int'(irq), 0);
        req = 5'b11010;
        @(negedge clk);
        chk("R8 high preempts low", int'(irq), 1);
        chk("R8 high vec", int'(vec), 1);
        nmi = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 hold irq", int'(irq), 1);
        chk("R7 hold vec", int'(vec), 1);
        pulse_ack();
        @(negedge clk);
        chk("R2 nmi preempts high", int'(irq), 1);
        chk("R2 nmi vec", int'(vec), 5);
        pulse_ack();
        nmi = 0;
        pulse_reti();
        @(negedge clk);
        chk("R9 high still in service", int'(irq), 0);
        pulse_reti();
        @(negedge clk);
        chk("R9 high cleared reoffer", int'(irq), 1);
        chk("R9 reoffer vec", int'(vec), 1);
        req = 5'b11000;
        pulse_ack();
        pulse_reti();
        @(negedge clk);
        chk("R9 low still in service", int'(irq), 0);
        pulse_reti();
        @(negedge clk);
        chk("R9 low cleared reoffer", int'(irq), 1);
        chk("R5 lower index in low group", int'(vec), 3);
        req = '0;
        pulse_ack();
        pulse_reti();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule